// File: doc/BRIEF.md
# Call and Interrupt Return-Stack Sequencer

This block moves a processor's return context between the core and a byte-wide data RAM. When an interrupt is taken or a subroutine is called, it stores the address of the next instruction together with the carry and zero flags as a two-byte frame. The frame is written at an 8-bit stack pointer that starts at address 0x00 and grows upward.

A subroutine return reads the frame back and hands the core only the counter. An interrupt return also hands back both flags and turns the global interrupt enable on again. Taking an interrupt turns that enable off. Firmware may also overwrite the pointer with the accumulator value.

Each request occupies exactly two RAM cycles while `busy` is high. The RAM is assumed to return read data in the same cycle as the address (asynchronous read). Interrupt priority and vector selection are handled elsewhere.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp` is 0x00, `ie` is 0, `busy` is 0, `pc_out` is 0, and `c_out` and `z_out` are 0.
- R2: A frame holds two bytes. The first byte, at the lower address, is carry in bit 7, zero in bit 6 and counter bits 13:8 in bits 5:0. The second byte is counter bits 7:0.
- R3: An interrupt or a call writes the first byte at `sp` and then increments `sp`. It then writes the second byte at the new `sp` and increments again, for a net change of +2. The values saved are `pc_in`, `c_in` and `z_in` as sampled when the request is accepted.
- R4: Accepting an interrupt clears `ie`. A call leaves `ie` unchanged.
- R5: An interrupt return decrements `sp` and reads the second byte at the new value. It then decrements again and reads the first byte. It restores `pc_out`, `c_out` and `z_out`, sets `ie`, and pulses `rvalid` for one cycle.
- R6: A subroutine return restores `pc_out` only. It leaves `c_out`, `z_out` and `ie` unchanged, decrements `sp` by two and pulses `rvalid`.
- R7: When the block is idle and no request is present, `ld_sp` loads `sp` from `acc` at the clock edge. A simultaneous request takes precedence and the load is dropped.
- R8: An accepted request holds `busy` high for exactly two cycles. Requests and `ld_sp` that arrive while `busy` is high are ignored.
- R9: When several requests are present in the same cycle, the order of precedence is interrupt, then call, then interrupt return, then subroutine return.
- R10: `sp` wraps modulo 256 on both increment and decrement.
- R11: `ram_we` and `ram_re` are never high together. Both are low when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_int | input | 1 | Interrupt acknowledge request |
| req_call | input | 1 | Subroutine call request |
| req_ret | input | 1 | Subroutine return request |
| req_reti | input | 1 | Interrupt return request |
| ld_sp | input | 1 | Load pointer from accumulator |
| acc | input | 8 | Accumulator value for the pointer load |
| pc_in | input | 14 | Next-instruction address to save |
| c_in | input | 1 | Carry flag to save |
| z_in | input | 1 | Zero flag to save |
| ram_rdata | input | 8 | RAM read data, valid in the same cycle as the address |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| pc_out | output | 14 | Restored counter |
| c_out | output | 1 | Restored carry flag |
| z_out | output | 1 | Restored zero flag |
| rvalid | output | 1 | One-cycle pulse when a restore completes |
| ie | output | 1 | Global interrupt enable |
| busy | output | 1 | Sequence in progress |
| sp | output | 8 | Stack pointer |

## Verification
The in-line properties check four things on every cycle. An accepted request holds `busy` for exactly two cycles. The pointer moves by exactly one on each write step and on each read step, with wrap. The write and read strobes stay exclusive. Taking an interrupt drops the enable. The bench scenarios cover the rest: the byte packing in RAM, the restored counter and flags for both return kinds, and that a plain return leaves the flags alone. They also cover the precedence order, the dropping of loads and requests while busy, and wrap across 0xFF and 0x00 with real frame data.

// File: rtl/stack_seq.sv
module stack_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_int,
  input  logic        req_call,
  input  logic        req_ret,
  input  logic        req_reti,
  input  logic        ld_sp,
  input  logic [7:0]  acc,
  input  logic [13:0] pc_in,
  input  logic        c_in,
  input  logic        z_in,
  input  logic [7:0]  ram_rdata,
  output logic [7:0]  ram_addr,
  output logic [7:0]  ram_wdata,
  output logic        ram_we,
  output logic        ram_re,
  output logic [13:0] pc_out,
  output logic        c_out,
  output logic        z_out,
  output logic        rvalid,
  output logic        ie,
  output logic        busy,
  output logic [7:0]  sp
);
  typedef enum logic [1:0] {IDLE, STEP1, STEP2} st_t;
  st_t st;
  logic        save_q, reti_q;
  logic [15:0] frame;
  logic [7:0]  lo_q;
  logic        any_req, accept;

  assign any_req   = req_int | req_call | req_ret | req_reti;
  assign accept    = (st == IDLE) && any_req;
  assign busy      = (st != IDLE);
  assign ram_we    = busy && save_q;
  assign ram_re    = busy && !save_q;
  assign ram_addr  = save_q ? sp : sp - 8'd1;
  assign ram_wdata = (st == STEP1) ? frame[15:8] : frame[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      sp     <= 8'd0;
      ie     <= 1'b0;
      pc_out <= '0;
      c_out  <= 1'b0;
      z_out  <= 1'b0;
      rvalid <= 1'b0;
      save_q <= 1'b0;
      reti_q <= 1'b0;
      frame  <= '0;
      lo_q   <= '0;
    end else begin
      rvalid <= 1'b0;
      case (st)
        IDLE: begin
          if (accept) begin
            st     <= STEP1;
            save_q <= req_int | req_call;
            reti_q <= !(req_int | req_call) && req_reti;
            frame  <= {c_in, z_in, pc_in};
            if (req_int) ie <= 1'b0;
          end else if (ld_sp) begin
            sp <= acc;
          end
        end
        STEP1: begin
          st <= STEP2;
          if (save_q) sp <= sp + 8'd1;
          else begin
            sp   <= sp - 8'd1;
            lo_q <= ram_rdata;
          end
        end
        default: begin
          st <= IDLE;
          if (save_q) sp <= sp + 8'd1;
          else begin
            sp     <= sp - 8'd1;
            pc_out <= {ram_rdata[5:0], lo_q};
            rvalid <= 1'b1;
            if (reti_q) begin
              c_out <= ram_rdata[7];
              z_out <= ram_rdata[6];
              ie    <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R8
  two_cycle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy ##1 busy ##1 !busy);
  // R3
  save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> sp == $past(sp) + 8'd1);
  // R5
  restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> sp == $past(sp) - 8'd1);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re) && (busy || (!ram_we && !ram_re)));
  // R4
  int_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_int) |=> !ie);
endmodule

// File: tb/stack_seq_test.sv
`timescale 1ns/1ps
module stack_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_int = 0, req_call = 0, req_ret = 0, req_reti = 0, ld_sp = 0;
  logic [7:0] acc = 0;
  logic [13:0] pc_in = 0;
  logic c_in = 0, z_in = 0;
  logic [7:0] ram_rdata, ram_addr, ram_wdata, sp;
  logic ram_we, ram_re, c_out, z_out, rvalid, ie, busy;
  logic [13:0] pc_out;
  logic [7:0] mem [256];
  logic [7:0] sh [256];
  int total = 0, bad = 0;
  logic [7:0] e_sp;
  logic e_ie, e_c, e_z, last_rv;
  logic [13:0] e_pc;

  always #2.5 clk = ~clk;

  stack_seq uut (.*);

  always_ff @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  // op: 0 interrupt, 1 call, 2 return, 3 interrupt return, 4 pointer load
  localparam logic [26:0] VEC [12] = '{
    {3'd4, 14'h0000, 1'b0, 1'b0, 8'hFE},
    {3'd1, 14'h1234, 1'b1, 1'b0, 8'h00},
    {3'd0, 14'h0ABC, 1'b0, 1'b1, 8'h00},
    {3'd3, 14'h0000, 1'b0, 1'b0, 8'h00},
    {3'd2, 14'h0000, 1'b0, 1'b0, 8'h00},
    {3'd4, 14'h0000, 1'b0, 1'b0, 8'h10},
    {3'd0, 14'h3FFF, 1'b1, 1'b1, 8'h00},
    {3'd1, 14'h0001, 1'b0, 1'b0, 8'h00},
    {3'd2, 14'h0000, 1'b0, 1'b0, 8'h00},
    {3'd3, 14'h0000, 1'b0, 1'b0, 8'h00},
    {3'd1, 14'h2000, 1'b1, 1'b1, 8'h00},
    {3'd2, 14'h0000, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] op, input logic [13:0] pc, input logic c, input logic z);
    @(negedge clk);
    req_int = (op == 0); req_call = (op == 1); req_ret = (op == 2); req_reti = (op == 3);
    pc_in = pc; c_in = c; z_in = z;
    @(negedge clk);
    req_int = 0; req_call = 0; req_ret = 0; req_reti = 0;
    chk("R8 busy step1", busy, 1);
    @(negedge clk);
    chk("R8 busy step2", busy, 1);
    @(negedge clk);
    chk("R8 busy done", busy, 0);
    last_rv = rvalid;
  endtask

  task automatic model_save(input logic is_int, input logic [13:0] pc, input logic c, input logic z);
    logic [7:0] b0, b1;
    b0 = {c, z, pc[13:8]};
    b1 = pc[7:0];
    chk("R2 R3 first byte", mem[e_sp], b0);
    chk("R2 R3 second byte", mem[e_sp + 8'd1], b1);
    sh[e_sp] = b0;
    sh[e_sp + 8'd1] = b1;
    e_sp = e_sp + 8'd2;
    if (is_int) e_ie = 1'b0;
  endtask

  task automatic model_restore(input logic is_reti);
    logic [7:0] b0, b1;
    b0 = sh[e_sp - 8'd2];
    b1 = sh[e_sp - 8'd1];
    e_pc = {b0[5:0], b1};
    if (is_reti) begin e_c = b0[7]; e_z = b0[6]; e_ie = 1'b1; end
    e_sp = e_sp - 8'd2;
    chk(is_reti ? "R5 rvalid" : "R6 rvalid", last_rv, 1);
  endtask

  task automatic chk_state(input string r);
    chk({r, " sp"}, sp, e_sp);
    chk({r, " pc"}, pc_out, e_pc);
    chk({r, " carry"}, c_out, e_c);
    chk({r, " zero"}, z_out, e_z);
    chk({r, " ie"}, ie, e_ie);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_sp = 0; e_ie = 0; e_c = 0; e_z = 0; e_pc = 0;
    // R1 reset state
    chk("R1 sp", sp, 0);
    chk("R1 ie", ie, 0);
    chk("R1 busy", busy, 0);
    chk("R1 pc", pc_out, 0);
    chk("R1 flags", {c_out, z_out}, 0);
    // R11 idle strobes
    chk("R11 idle strobes", {ram_we, ram_re}, 0);

    for (int i = 0; i < 12; i++) begin
      logic [2:0] op;
      logic [13:0] pc;
      logic c, z;
      logic [7:0] a;
      {op, pc, c, z, a} = VEC[i];
      if (op == 4) begin
        @(negedge clk); ld_sp = 1; acc = a;
        @(negedge clk); ld_sp = 0;
        e_sp = a;
        chk_state("R7 load");
      end else begin
        run_req(op, pc, c, z);
        if (op <= 1) begin
          model_save(op == 0, pc, c, z);
          chk_state(op == 0 ? "R4 R10 interrupt" : "R3 R10 call");
        end else begin
          model_restore(op == 3);
          chk_state(op == 3 ? "R5 R10 reti" : "R6 R10 ret");
        end
      end
    end

    // R8 requests and loads during busy are ignored
    @(negedge clk); req_call = 1; pc_in = 14'h0155; c_in = 0; z_in = 1;
    @(negedge clk); req_call = 0; ld_sp = 1; acc = 8'h77; req_ret = 1;
    @(negedge clk);
    @(negedge clk); ld_sp = 0; req_ret = 0;
    model_save(1'b0, 14'h0155, 1'b0, 1'b1);
    chk_state("R8 ignored while busy");
    @(negedge clk);
    chk("R8 no late start", busy, 0);

    // R9 call beats return; R7 request beats load
    @(negedge clk); req_call = 1; req_ret = 1; ld_sp = 1; acc = 8'h55;
    pc_in = 14'h2AAA; c_in = 1; z_in = 0;
    @(negedge clk); req_call = 0; req_ret = 0; ld_sp = 0;
    @(negedge clk); @(negedge clk);
    model_save(1'b0, 14'h2AAA, 1'b1, 1'b0);
    chk_state("R9 R7 call over return and load");

    // R9 interrupt beats interrupt return
    @(negedge clk); req_int = 1; req_reti = 1; pc_in = 14'h0F0F; c_in = 1; z_in = 1;
    @(negedge clk); req_int = 0; req_reti = 0;
    @(negedge clk); @(negedge clk);
    model_save(1'b1, 14'h0F0F, 1'b1, 1'b1);
    chk_state("R9 R4 interrupt over reti");

    // R5 unwind the interrupt frame, then R9 reti beats ret
    run_req(3'd3, 14'h0, 1'b0, 1'b0);
    model_restore(1'b1);
    chk_state("R5 reti restore");
    @(negedge clk); req_reti = 1; req_ret = 1;
    @(negedge clk); req_reti = 0; req_ret = 0;
    @(negedge clk); @(negedge clk);
    last_rv = rvalid;
    model_restore(1'b1);
    chk_state("R9 reti over ret");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule